// File: doc/BRIEF.md
# Bus Clock-Low Timeout Watchdog

This block guards a two-wire management bus port against a hung clock line. It takes the already-synchronized clock line level and counts system clock cycles for as long as that line stays low. Once a single low period reaches 35 milliseconds, it raises a one-cycle timeout pulse. The attached controller or target logic uses this pulse as its protocol reset. In the same cycle, the block blocks that logic's data and clock drive enables, so the port lets go of both wires.

Software sets the length of a millisecond as a number of system clocks on an input. The block turns that value into a registered cycle limit. A sticky flag records that a timeout has happened and stays set until software clears it. The block ignores a clear request while the line is still stuck low after a timeout. The block only arms again after it has seen the clock line high. Any low phase at a legal bus rate, which is at least 10 kHz, ends far below the limit, so normal traffic never trips the watchdog.

Top module: `scl_low_watchdog`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tmo_pulse_o` and `tmo_flag_o` are 0, and each drive enable output equals its input.
- R2: The cycle limit is 35 × `clks_per_ms_i`, taken into a register one clock after the input changes. `tmo_pulse_o` goes high in the cycle that follows the clock edge at which `scl_i` has been sampled low for the limit's number of consecutive edges.
- R3: Sampling `scl_i` high at any edge restarts the low count, so low periods shorter than the limit that are separated by high samples never produce a pulse.
- R4: `tmo_pulse_o` is high for exactly one cycle. After a timeout, no further pulse occurs until `scl_i` has been sampled high and a new full-length low period has elapsed.
- R5: From the pulse cycle until the edge at which `scl_i` is next sampled high, `sda_oe_o` and `scl_oe_o` are forced to 0. Outside that window, they equal `sda_oe_i` and `scl_oe_i`.
- R6: `tmo_flag_o` goes high in the same cycle as the pulse. It stays high until `stat_clr_i` is sampled at an edge where the line has been seen high since the timeout.
- R7: A `stat_clr_i` request has no effect on `tmo_flag_o` while the block is timed out and `scl_i` is still low.
- R8: When `clks_per_ms_i` is 0, the timeout is disabled: no pulse fires however long `scl_i` stays low.
- R9: If a clear request and a timeout fall on the same edge, the timeout wins and `tmo_flag_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronized clock line level |
| clks_per_ms_i | input | MS_W | System clocks per millisecond; 0 disables the timeout |
| stat_clr_i | input | 1 | Software request to clear the sticky flag |
| sda_oe_i | input | 1 | Data-line drive enable from the attached port logic |
| scl_oe_i | input | 1 | Clock-line drive enable from the attached port logic |
| tmo_pulse_o | output | 1 | One-cycle timeout pulse, used as the port's protocol reset |
| tmo_flag_o | output | 1 | Sticky timeout status |
| sda_oe_o | output | 1 | Gated data-line drive enable |
| scl_oe_o | output | 1 | Gated clock-line drive enable |

## Verification
Inputs change on falling clock edges, and outputs are compared on the next falling edge. Each comparison therefore sees exactly one rising edge of the design's response. The pulse, the flag and the re-enabled drive enables all appear one cycle after the edge that samples their cause. For example, the pulse and the flag appear after the limit-th consecutive low sample, and the enables return after the first high sample. A new `clks_per_ms_i` needs one extra edge to reach the limit register, so the bench lets it settle before it starts a low period. In the random phase, a per-edge reference model built from the requirements predicts all four outputs. The directed cases check them at the exact count of waited edges, plus or minus one.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  // Arming state of the low-period watchdog
  typedef enum logic {
    ST_ARMED   = 1'b0,
    ST_TRIPPED = 1'b1
  } trip_e;

endpackage

// File: rtl/smbto_limit.sv
module smbto_limit #(
  parameter int MS_W     = 20,
  parameter int LIMIT_MS = 35,
  parameter int LIM_W    = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MS_W-1:0]  clks_per_ms_i,
  output logic [LIM_W-1:0] limit_o,
  output logic             en_o
);

  localparam logic [LIM_W-1:0] MS_FACTOR = LIM_W'(LIMIT_MS);

  logic [LIM_W-1:0] limit_q;
  logic             en_q;

  // Register the product so the multiplier stays out of the compare path
  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      en_q    <= 1'b0;
    end else begin
      limit_q <= LIM_W'(clks_per_ms_i) * MS_FACTOR;
      en_q    <= |clks_per_ms_i;
    end
  end

  assign limit_o = limit_q;
  assign en_o    = en_q;

  // R8
  limit_zero_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_o == '0) |-> !en_o);

endmodule

// File: rtl/smbto_lowcnt.sv
module smbto_lowcnt
  import smbto_pkg::*;
#(
  parameter int LIM_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             en_i,
  output logic             fire_o,
  output logic             pulse_o,
  output trip_e            state_o
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W:0]   cnt_inc;
  trip_e            st_q;
  logic             pulse_q;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // Fires at the edge that samples the limit-th consecutive low level
  assign fire_o = en_i && !scl_i && (st_q == ST_ARMED) &&
                  (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      st_q    <= ST_ARMED;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_o;
      if (scl_i) begin
        cnt_q <= '0;
        st_q  <= ST_ARMED;
      end else if (st_q == ST_ARMED) begin
        if (fire_o) begin
          st_q <= ST_TRIPPED;
        end
        if (!(&cnt_q)) begin
          cnt_q <= cnt_inc[LIM_W-1:0];
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign state_o = st_q;

  // R3
  high_restarts_count_chk: assert property (@(posedge clk) disable iff (rst)
    scl_i |=> (cnt_q == '0));

  // R4
  tripped_stays_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_TRIPPED) && !scl_i) |=> !pulse_o);

endmodule

// File: rtl/smbto_status.sv
module smbto_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic flag_o
);

  logic flag_q;

  // Setting has priority; a clear is refused while the line is still stuck
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i && !hold_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R7
  clear_refused_when_stuck_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && clr_i && hold_i) |=> flag_o);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);

endmodule

// File: rtl/scl_low_watchdog.sv
module scl_low_watchdog
  import smbto_pkg::*;
#(
  parameter int MS_W     = 20,
  parameter int LIMIT_MS = 35
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic [MS_W-1:0] clks_per_ms_i,
  input  logic            stat_clr_i,
  input  logic            sda_oe_i,
  input  logic            scl_oe_i,
  output logic            tmo_pulse_o,
  output logic            tmo_flag_o,
  output logic            sda_oe_o,
  output logic            scl_oe_o
);

  localparam int LIM_W = MS_W + $clog2(LIMIT_MS + 1);

  logic [LIM_W-1:0] limit;
  logic             lim_en;
  logic             fire;
  logic             pulse;
  trip_e            trip_st;
  logic             stuck;
  logic             release_drv;

  smbto_limit #(
    .MS_W    (MS_W),
    .LIMIT_MS(LIMIT_MS),
    .LIM_W   (LIM_W)
  ) u_limit (
    .clk          (clk),
    .rst          (rst),
    .clks_per_ms_i(clks_per_ms_i),
    .limit_o      (limit),
    .en_o         (lim_en)
  );

  smbto_lowcnt #(
    .LIM_W(LIM_W)
  ) u_lowcnt (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .limit_i(limit),
    .en_i   (lim_en),
    .fire_o (fire),
    .pulse_o(pulse),
    .state_o(trip_st)
  );

  assign stuck = (trip_st == ST_TRIPPED) && !scl_i;

  smbto_status u_status (
    .clk   (clk),
    .rst   (rst),
    .set_i (fire),
    .clr_i (stat_clr_i),
    .hold_i(stuck),
    .flag_o(tmo_flag_o)
  );

  // Drive enables stay blocked from the pulse cycle until a high sample re-arms
  assign release_drv = (trip_st == ST_TRIPPED);
  assign sda_oe_o    = sda_oe_i && !release_drv;
  assign scl_oe_o    = scl_oe_i && !release_drv;
  assign tmo_pulse_o = pulse;

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse_o |=> !tmo_pulse_o);

  // R5
  drive_released_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse_o |-> (!sda_oe_o && !scl_oe_o));

  // R6
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse_o |-> tmo_flag_o);

  // R2
  pulse_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_pulse_o) |-> !$past(scl_i));

endmodule

// File: tb/scl_low_watchdog_bench.sv
module scl_low_watchdog_bench;

  localparam int MS_W = 20;

  logic            clk = 1'b0;
  logic            rst;
  logic            scl;
  logic [MS_W-1:0] cpm;
  logic            clr;
  logic            sda_oe_in;
  logic            scl_oe_in;
  logic            pulse;
  logic            flag;
  logic            sda_oe_out;
  logic            scl_oe_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  scl_low_watchdog #(.MS_W(MS_W), .LIMIT_MS(35)) u_scl_low_watchdog (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl),
    .clks_per_ms_i(cpm),
    .stat_clr_i   (clr),
    .sda_oe_i     (sda_oe_in),
    .scl_oe_i     (scl_oe_in),
    .tmo_pulse_o  (pulse),
    .tmo_flag_o   (flag),
    .sda_oe_o     (sda_oe_out),
    .scl_oe_o     (scl_oe_out)
  );

  function automatic int limit_of(int ms_clks);
    return ms_clks * 35;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model built from the requirements, advanced at each rising edge
  int  m_run, m_lim;
  bit  m_armed, m_pulse, m_flag, m_fire, m_old_armed;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_run = 0; m_lim = 0; m_armed = 1; m_pulse = 0; m_flag = 0;
    end else begin
      m_old_armed = m_armed;
      m_run  = scl ? 0 : m_run + 1;
      m_fire = m_armed && !scl && (m_lim != 0) && (m_run >= m_lim);
      m_pulse = m_fire;
      if (scl) m_armed = 1;
      else if (m_fire) m_armed = 0;
      if (m_fire) m_flag = 1;
      else if (clr && !(!m_old_armed && !scl)) m_flag = 0;
      m_lim = limit_of(int'(cpm));
    end
  end

  // Per-cycle comparison against the model during the random phase
  always @(negedge clk) begin
    if (model_on) begin
      check("R2/R4 pulse", int'(pulse), int'(m_pulse));
      check("R6/R7 flag", int'(flag), int'(m_flag));
      check("R5 sda_oe", int'(sda_oe_out), int'(sda_oe_in && m_armed));
      check("R5 scl_oe", int'(scl_oe_out), int'(scl_oe_in && m_armed));
    end
  end

  // Watchdog
  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    rst = 1'b1; scl = 1'b1; cpm = '0; clr = 1'b0;
    sda_oe_in = 1'b1; scl_oe_in = 1'b1;
    tick(3);
    // R1 during reset
    check("R1 pulse in reset", int'(pulse), 0);
    check("R1 flag in reset", int'(flag), 0);
    check("R1 sda_oe pass", int'(sda_oe_out), 1);
    rst = 1'b0;
    tick(1);
    check("R1 pulse after reset", int'(pulse), 0);
    check("R1 scl_oe pass", int'(scl_oe_out), 1);

    // R2: limit 70 cycles
    cpm = 20'd2;
    tick(3);
    scl = 1'b0;
    tick(69);
    check("R2 no pulse one edge early", int'(pulse), 0);
    tick(1);
    check("R2 pulse at limit", int'(pulse), 1);
    check("R6 flag with pulse", int'(flag), 1);
    check("R5 sda_oe off on pulse", int'(sda_oe_out), 0);
    check("R5 scl_oe off on pulse", int'(scl_oe_out), 0);
    tick(1);
    check("R4 pulse one cycle", int'(pulse), 0);
    check("R5 sda_oe held off", int'(sda_oe_out), 0);
    // R7: clear while stuck is refused
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check("R7 clear ignored while stuck", int'(flag), 1);
    tick(200);
    check("R4 no second pulse while low", int'(pulse), 0);
    scl = 1'b1;
    tick(1);
    check("R5 enables back after high", int'(sda_oe_out), 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check("R6 flag cleared", int'(flag), 0);

    // R3: low 69, high 1, low 69 -> no pulse
    scl = 1'b0; tick(69);
    scl = 1'b1; tick(1);
    scl = 1'b0; tick(69);
    check("R3 restarted count no pulse", int'(pulse), 0);
    check("R3 flag stays clear", int'(flag), 0);
    tick(1);
    check("R3 second full period fires", int'(pulse), 1);
    scl = 1'b1; tick(1);
    clr = 1'b1; tick(1); clr = 1'b0;

    // R9: clear on the firing edge loses to the timeout
    scl = 1'b0; tick(69);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R9 pulse", int'(pulse), 1);
    check("R9 set wins over clear", int'(flag), 1);
    scl = 1'b1; tick(1);
    clr = 1'b1; tick(1); clr = 1'b0;

    // R8: zero disables
    cpm = '0; tick(3);
    scl = 1'b0;
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (pulse) check("R8 disabled no pulse", int'(pulse), 0);
    end
    check("R8 no flag when disabled", int'(flag), 0);
    check("R8 enables pass", int'(scl_oe_out), 1);
    scl = 1'b1; tick(2);

    // Random phase against the model
    model_on = 1'b1;
    for (int seg = 0; seg < 60; seg++) begin
      cpm = MS_W'($urandom_range(0, 3));
      scl = 1'b1;
      tick(3);
      for (int run = 0; run < 8; run++) begin
        int len;
        len = $urandom_range(1, 130);
        scl = ($urandom_range(0, 1) == 1);
        for (int c = 0; c < len; c++) begin
          sda_oe_in = ($urandom_range(0, 1) == 1);
          scl_oe_in = ($urandom_range(0, 1) == 1);
          clr = ($urandom_range(0, 7) == 0);
          tick(1);
        end
      end
    end
    model_on = 1'b0;
    clr = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule